// File: doc/BRIEF.md
# ATA PIO Host Cycle Sequencer

This block is the host-side engine for single 16-bit programmed-I/O register accesses on a parallel ATA-style disk bus. A local client presents a 5-bit register address, a direction flag, write data and a PIO transfer mode from 0 to 4. The block then runs one bus access as four timed phases:

- **address setup**: address and chip selects valid, strobe inactive.
- **strobe active**: the read or write strobe is low.
- **address hold**: strobe inactive, address and write data still driven.
- **recovery**: chip selects released.

When recovery ends, a one-cycle done pulse is raised. On reads, the captured word is returned at the same time.

Every phase length is derived from the mode's nanosecond limits. The conversion rounds up, using the clock period given as a parameter. A device can hold the strobe active longer by keeping the IORDY line low. That line is resynchronised with two flops before it is used.

Top module: `ata_pio_host`

## Requirements
- R1: After a synchronous active-low reset, including one taken in the middle of an access, busy and done are 0, both strobes are 1, bus_doe is 0 and both chip selects are 1. No strobe is ever low while busy is 0.
- R2: During an access, bus_cs1_n = NOT addr[4], bus_cs0_n = NOT addr[3] and bus_da = addr[2:0]. These stay stable while the strobe is low.
- R3: A request is taken on a rising clock edge where req is 1 and busy is 0. The strobe then stays high for exactly S clocks, with busy 1 and the address valid, before it falls. S = ceil(setup_ns / CLK_NS), where setup_ns is 70, 50, 30, 30 or 25 for modes 0 to 4.
- R4: With IORDY high, the strobe stays low for exactly A = ceil(active_ns / CLK_NS) clocks. active_ns is 290 for modes 0 to 2, 80 for mode 3 and 70 for mode 4.
- R5: If IORDY goes low in the first strobe-low clock and stays low for D clocks, the strobe stays low for max(A, D+3) clocks. The extra 3 clocks are the two synchroniser flops plus the release edge.
- R6: After the strobe rises, the chip selects and address stay asserted for H clocks, with the strobe high. For writes, bus_doe and bus_dout are also held for those H clocks. H = max(ceil(addr_hold_ns/CLK_NS), ceil(wr_hold_ns/CLK_NS)):
  - addr_hold_ns is 20, 15, 10, 10 and 10 for modes 0 to 4.
  - wr_hold_ns is 30, 20, 15, 10 and 10 for modes 0 to 4.
- R7: A recovery phase of R clocks follows, with busy 1 and both chip selects high. Then done pulses for one clock and busy is 0. R is the largest of these three values:
  - 0;
  - ceil(cycle_ns/CLK_NS) − (S+A+H), where cycle_ns is 600, 383, 330, 180 and 120 for modes 0 to 4;
  - ceil(gap_ns/CLK_NS) − H, where gap_ns is 70 in mode 3, 25 in mode 4 and 0 otherwise.
- R8: On reads, bus_din is captured on the clock edge that releases the read strobe. It is presented on rdata during the done pulse.
- R9: A write uses only bus_wr_n and a read only bus_rd_n; the two are never low together. On writes, bus_doe is 1 and bus_dout carries the write data from setup through hold. bus_doe is never 1 while bus_rd_n is low.
- R10: A request raised while busy is 1 is ignored: no extra access starts.
- R11: Mode values 5 to 7 use the mode 0 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Register address (top two bits select the chip select) |
| req_mode | input | 3 | PIO mode 0..4 |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid with done |
| bus_cs1_n | output | 1 | Chip select 1, active low |
| bus_cs0_n | output | 1 | Chip select 0, active low |
| bus_da | output | 3 | Device register address |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_doe | output | 1 | Data bus output enable |
| bus_dout | output | 16 | Data driven to the bus |
| bus_din | input | 16 | Data read from the bus |
| bus_iordy | input | 1 | Device ready, asynchronous |

## Verification
Reads are run in each mode 0 to 4, and once with an out-of-range mode. Each mode gives its own setup, active, hold and recovery counts, which tells apart errors in the mode lookup and errors in the rounding. Mode 2 checks the case where recovery is zero, and modes 3 and 4 check the case where the strobe-inactive minimum sets recovery.

Writes followed by reads of the same addresses show that the data path and the chip-select decoding agree. A short IORDY low pulse must not stretch the strobe, while a long one must stretch it by the synchroniser latency.

A request held during a busy access must start nothing. A reset taken mid-strobe must return every bus line to its idle level.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  localparam int TCNT_W = 16;
  typedef logic [TCNT_W-1:0] tcount_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_ACTIVE, PH_HOLD, PH_RECOV
  } phase_t;

  typedef struct packed {
    tcount_t setup;
    tcount_t active;
    tcount_t hold;
    tcount_t recov;
  } pio_timing_t;

  // round a nanosecond figure up to whole clocks
  function automatic int ns2clk(int ns, int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int setup_ns(logic [2:0] m);
    case (m)
      3'd1: return 50;
      3'd2: return 30;
      3'd3: return 30;
      3'd4: return 25;
      default: return 70;
    endcase
  endfunction

  function automatic int active_ns(logic [2:0] m);
    case (m)
      3'd3: return 80;
      3'd4: return 70;
      default: return 290;
    endcase
  endfunction

  function automatic int addr_hold_ns(logic [2:0] m);
    case (m)
      3'd1: return 15;
      3'd2, 3'd3, 3'd4: return 10;
      default: return 20;
    endcase
  endfunction

  function automatic int wr_hold_ns(logic [2:0] m);
    case (m)
      3'd1: return 20;
      3'd2: return 15;
      3'd3, 3'd4: return 10;
      default: return 30;
    endcase
  endfunction

  function automatic int cycle_ns(logic [2:0] m);
    case (m)
      3'd1: return 383;
      3'd2: return 330;
      3'd3: return 180;
      3'd4: return 120;
      default: return 600;
    endcase
  endfunction

  function automatic int gap_ns(logic [2:0] m);
    case (m)
      3'd3: return 70;
      3'd4: return 25;
      default: return 0;
    endcase
  endfunction

  function automatic pio_timing_t calc_timing(logic [2:0] m, int clk_ns);
    pio_timing_t t;
    int s, a, h, r;
    s = max2(1, ns2clk(setup_ns(m), clk_ns));
    a = max2(1, ns2clk(active_ns(m), clk_ns));
    h = max2(1, max2(ns2clk(addr_hold_ns(m), clk_ns), ns2clk(wr_hold_ns(m), clk_ns)));
    r = max2(0, ns2clk(cycle_ns(m), clk_ns) - (s + a + h));
    r = max2(r, ns2clk(gap_ns(m), clk_ns) - h);
    t.setup  = tcount_t'(s);
    t.active = tcount_t'(a);
    t.hold   = tcount_t'(h);
    t.recov  = tcount_t'(r);
    return t;
  endfunction

endpackage

// File: rtl/ata_pio_timing.sv
module ata_pio_timing
  import ata_pio_pkg::*;
#(
  parameter int CLK_NS = 4,
  parameter int MODE_W = 3
) (
  input  logic [MODE_W-1:0] mode,
  output pio_timing_t       tim
);
  logic [2:0] mode_eff;

  // modes above 4 fall back to the slowest timing
  assign mode_eff = (mode > MODE_W'(4)) ? 3'd0 : 3'(mode);
  assign tim      = calc_timing(mode_eff, CLK_NS);
endmodule

// File: rtl/ata_pio_sync.sv
module ata_pio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) sr[i] <= 1'b1;
        else        sr[i] <= (i == 0) ? d : sr[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/ata_pio_fsm.sv
module ata_pio_fsm
  import ata_pio_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              iordy_s,
  input  pio_timing_t       tim,
  input  logic [DATA_W-1:0] bus_din,
  output logic [MODE_W-1:0] mode_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              cs_on,
  output logic              rd_n,
  output logic              wr_n,
  output logic              doe,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              done,
  output logic              accept,
  output logic              strobe_release,
  output logic              cycle_end
);
  phase_t  state, nxt;
  tcount_t cnt;
  logic    wr_q, wr_sel, active_met, drive_ph;

  assign accept     = (state == PH_IDLE) && req;
  assign active_met = (cnt >= tim.active - 1'b1);

  always_comb begin
    nxt = state;
    case (state)
      PH_IDLE:   if (req) nxt = PH_SETUP;
      PH_SETUP:  if (cnt == tim.setup - 1'b1) nxt = PH_ACTIVE;
      PH_ACTIVE: if (active_met && iordy_s) nxt = PH_HOLD;
      PH_HOLD:   if (cnt == tim.hold - 1'b1)
                   nxt = (tim.recov == '0) ? PH_IDLE : PH_RECOV;
      PH_RECOV:  if (cnt == tim.recov - 1'b1) nxt = PH_IDLE;
      default:   nxt = PH_IDLE;
    endcase
  end

  assign strobe_release = (state == PH_ACTIVE) && (nxt == PH_HOLD);
  assign cycle_end      = (state != PH_IDLE) && (nxt == PH_IDLE);
  assign wr_sel         = accept ? req_wr : wr_q;
  assign drive_ph       = (nxt == PH_SETUP) || (nxt == PH_ACTIVE) || (nxt == PH_HOLD);
  assign busy           = (state != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PH_IDLE;
      cnt   <= '0;
      wr_q  <= 1'b0;
      addr_q <= '0;
      mode_q <= '0;
      dout  <= '0;
      rdata <= '0;
      done  <= 1'b0;
      cs_on <= 1'b0;
      rd_n  <= 1'b1;
      wr_n  <= 1'b1;
      doe   <= 1'b0;
    end else begin
      state <= nxt;
      if (state != nxt)        cnt <= '0;
      else if (cnt != '1)      cnt <= cnt + 1'b1;
      if (accept) begin
        wr_q   <= req_wr;
        addr_q <= req_addr;
        mode_q <= req_mode;
        dout   <= req_wdata;
      end
      if (strobe_release && !wr_q) rdata <= bus_din;
      done  <= cycle_end;
      cs_on <= drive_ph;
      rd_n  <= !((nxt == PH_ACTIVE) && !wr_sel);
      wr_n  <= !((nxt == PH_ACTIVE) && wr_sel);
      doe   <= drive_ph && wr_sel;
    end
  end
endmodule

// File: rtl/ata_pio_host.sv
module ata_pio_host
  import ata_pio_pkg::*;
#(
  parameter int CLK_NS    = 4,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int MODE_W    = 3,
  parameter int SYNC_STG  = 2,
  localparam int DA_W     = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_cs1_n,
  output logic              bus_cs0_n,
  output logic [DA_W-1:0]   bus_da,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_doe,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_iordy
);
  pio_timing_t       tim;
  logic [MODE_W-1:0] mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cs_on, iordy_s;
  logic              accept, strobe_release, cycle_end;

  ata_pio_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_iordy), .q(iordy_s)
  );

  ata_pio_timing #(.CLK_NS(CLK_NS), .MODE_W(MODE_W)) u_timing (
    .mode(mode_q), .tim(tim)
  );

  ata_pio_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
    .req_addr(req_addr), .req_mode(req_mode), .req_wdata(req_wdata),
    .iordy_s(iordy_s), .tim(tim), .bus_din(bus_din),
    .mode_q(mode_q), .addr_q(addr_q), .cs_on(cs_on),
    .rd_n(bus_rd_n), .wr_n(bus_wr_n), .doe(bus_doe), .dout(bus_dout),
    .rdata(rdata), .busy(busy), .done(done), .accept(accept),
    .strobe_release(strobe_release), .cycle_end(cycle_end)
  );

  // top two address bits become the inverted chip selects
  assign bus_cs1_n = cs_on ? ~addr_q[ADDR_W-1] : 1'b1;
  assign bus_cs0_n = cs_on ? ~addr_q[ADDR_W-2] : 1'b1;
  assign bus_da    = addr_q[DA_W-1:0];
endmodule

// File: rtl/ata_pio_host_chk.sv
module ata_pio_host_chk #(
  parameter int DA_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            bus_rd_n,
  input logic            bus_wr_n,
  input logic            bus_doe,
  input logic            bus_cs0_n,
  input logic            bus_cs1_n,
  input logic [DA_W-1:0] bus_da,
  input logic            strobe_release,
  input logic            cycle_end
);
  // R9
  never_both_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  // R9
  doe_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> bus_rd_n);

  // R1
  strobe_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> busy);

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!bus_rd_n && $past(!bus_rd_n)) || (!bus_wr_n && $past(!bus_wr_n)))
      |-> ($stable(bus_da) && $stable(bus_cs0_n) && $stable(bus_cs1_n)));

  // R6
  hold_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_release |=> (bus_rd_n && bus_wr_n && busy && !(bus_cs0_n && bus_cs1_n)));

  // R7
  end_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> (done && !busy));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind ata_pio_host ata_pio_host_chk #(.DA_W(DA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_doe(bus_doe),
  .bus_cs0_n(bus_cs0_n), .bus_cs1_n(bus_cs1_n), .bus_da(bus_da),
  .strobe_release(strobe_release), .cycle_end(cycle_end)
);

// File: tb/test_ata_pio_host.sv
`timescale 1ns/1ps
module test_ata_pio_host;
  localparam int CLK = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_wr = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [2:0]  req_mode = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done;
  logic [15:0] rdata, bus_dout, bus_din;
  logic        bus_cs1_n, bus_cs0_n, bus_rd_n, bus_wr_n, bus_doe;
  logic [2:0]  bus_da;
  logic        iordy = 1'b1;

  always #(CLK/2) clk = ~clk;

  ata_pio_host #(.CLK_NS(CLK)) i_ata_pio_host (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_mode(req_mode), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .bus_cs1_n(bus_cs1_n), .bus_cs0_n(bus_cs0_n), .bus_da(bus_da),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_doe(bus_doe),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_iordy(iordy)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected timing tables, restated from the requirements
  int t_set[5] = '{70, 50, 30, 30, 25};
  int t_act[5] = '{290, 290, 290, 80, 70};
  int t_ah[5]  = '{20, 15, 10, 10, 10};
  int t_wh[5]  = '{30, 20, 15, 10, 10};
  int t_cyc[5] = '{600, 383, 330, 180, 120};
  int t_gap[5] = '{0, 0, 0, 70, 25};

  function automatic int clocks(int ns);
    int n = 0;
    while (n * CLK < ns) n++;
    return n;
  endfunction

  typedef struct {
    bit          wr;
    logic [4:0]  addr;
    logic [15:0] data;
    int s, a, h, r;
    string tag;
  } item_t;

  item_t exp_q[$];
  logic [15:0] exp_mem [32];
  logic [15:0] dev_mem [32];
  int cur_dly = 0;
  bit mon_off = 0;

  function automatic logic [4:0] bus_addr();
    return {~bus_cs1_n, ~bus_cs0_n, bus_da};
  endfunction

  assign bus_din = !bus_rd_n ? dev_mem[bus_addr()] : 16'hBEEF;

  task automatic do_access(input bit wr, input logic [4:0] addr, input logic [15:0] data,
                           input logic [2:0] mode, input int dly);
    item_t it;
    int m, x;
    m = (mode > 3'd4) ? 0 : int'(mode);
    it.wr = wr; it.addr = addr;
    it.s = clocks(t_set[m]);
    it.a = clocks(t_act[m]);
    it.h = clocks(t_ah[m]) > clocks(t_wh[m]) ? clocks(t_ah[m]) : clocks(t_wh[m]);
    it.r = clocks(t_cyc[m]) - (it.s + it.a + it.h);
    x = clocks(t_gap[m]) - it.h;
    if (x > it.r) it.r = x;
    if (it.r < 0) it.r = 0;
    it.tag = (mode > 3'd4) ? "R11" : "R4";
    if (dly > 0 && dly + 3 > it.a) begin it.a = dly + 3; it.tag = "R5"; end
    if (wr) begin it.data = data; exp_mem[addr] = data; end
    else    it.data = exp_mem[addr];
    exp_q.push_back(it);
    cur_dly = dly;
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = addr; req_wdata = data; req_mode = mode;
    @(negedge clk);
    while (!busy) @(negedge clk);
    req = 1'b0; req_addr = ~addr; req_wdata = ~data;
    while (!done) @(negedge clk);
  endtask

  // device model and scoreboard monitor
  int s_cnt, a_cnt, h_cnt, r_cnt, icnt;
  bit seen, bad_addr, bad_dir, bad_doe, prev_lo, prev_wr;
  item_t head;

  always @(negedge clk) begin
    if (!rst_n || mon_off) begin
      s_cnt = 0; a_cnt = 0; h_cnt = 0; r_cnt = 0; seen = 0;
      bad_addr = 0; bad_dir = 0; bad_doe = 0;
      prev_lo = 0; prev_wr = 1; iordy = 1'b1;
    end else begin
      automatic bit lo = !bus_rd_n || !bus_wr_n;
      if (lo && !prev_lo) begin
        if (cur_dly > 0) begin iordy = 1'b0; icnt = cur_dly - 1; end
      end else if (!iordy) begin
        if (icnt > 0) icnt--; else iordy = 1'b1;
      end
      if (bus_wr_n && !prev_wr) dev_mem[bus_addr()] = bus_dout;
      if (busy) begin
        if (lo) begin
          if (!prev_lo) begin
            if (exp_q.size() == 0) chk(0, "R10 unexpected access", 1, 0);
            else begin
              head = exp_q[0];
              if (bus_addr() != head.addr) bad_addr = 1;
              if (head.wr ? bus_wr_n : bus_rd_n) bad_dir = 1;
            end
          end
          if (head.wr && (!bus_doe || bus_dout != head.data)) bad_doe = 1;
          if (!head.wr && bus_doe) bad_doe = 1;
          a_cnt++; seen = 1;
        end else if (!seen) s_cnt++;
        else if (!(bus_cs0_n && bus_cs1_n)) begin
          h_cnt++;
          if (bus_doe != head.wr) bad_doe = 1;
        end else begin
          r_cnt++;
          if (bus_doe) bad_doe = 1;
        end
      end
      if (done) begin
        if (exp_q.size() == 0) chk(0, "R10 done without request", 1, 0);
        else begin
          head = exp_q.pop_front();
          chk(s_cnt == head.s, {head.tag, " R3 setup clocks"}, s_cnt, head.s);
          chk(a_cnt == head.a, {head.tag, " active clocks"}, a_cnt, head.a);
          chk(h_cnt == head.h, "R6 hold clocks", h_cnt, head.h);
          chk(r_cnt == head.r, "R7 recovery clocks", r_cnt, head.r);
          chk(!busy, "R7 busy low with done", busy, 0);
          chk(!bad_addr, "R2 address and chip selects", bad_addr, 0);
          chk(!bad_dir, "R9 strobe direction", bad_dir, 0);
          chk(!bad_doe, "R9 output enable and write data", bad_doe, 0);
          if (!head.wr) chk(rdata == head.data, "R8 read data", rdata, head.data);
        end
        s_cnt = 0; a_cnt = 0; h_cnt = 0; r_cnt = 0; seen = 0;
        bad_addr = 0; bad_dir = 0; bad_doe = 0;
      end
      prev_lo = lo; prev_wr = bus_wr_n;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      dev_mem[i] = 16'(i * 16'h0101 + 16'h3000);
      exp_mem[i] = dev_mem[i];
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1 busy/done at reset", {busy, done}, 0);
    chk(bus_rd_n && bus_wr_n, "R1 strobes at reset", {bus_rd_n, bus_wr_n}, 3);
    chk(!bus_doe && bus_cs0_n && bus_cs1_n, "R1 doe/cs at reset", {bus_doe, bus_cs1_n, bus_cs0_n}, 3);
    rst_n = 1'b1;
    @(negedge clk);

    do_access(0, 5'h10, 16'h0, 3'd0, 0);
    do_access(0, 5'h09, 16'h0, 3'd1, 0);
    do_access(0, 5'h1B, 16'h0, 3'd2, 0);
    do_access(0, 5'h0C, 16'h0, 3'd3, 0);
    do_access(0, 5'h17, 16'h0, 3'd4, 0);
    do_access(1, 5'h0A, 16'hA5C3, 3'd4, 0);
    do_access(0, 5'h0A, 16'h0, 3'd3, 0);
    do_access(1, 5'h1F, 16'h5A3C, 3'd0, 0);
    do_access(0, 5'h1F, 16'h0, 3'd2, 0);
    do_access(0, 5'h11, 16'h0, 3'd6, 0);      // R11
    do_access(0, 5'h12, 16'h0, 3'd4, 30);     // R5 stretched
    do_access(1, 5'h08, 16'h1234, 3'd3, 40);  // R5 stretched write
    do_access(0, 5'h08, 16'h0, 3'd0, 5);      // short IORDY low, no stretch

    // R10 request while busy
    fork
      do_access(0, 5'h13, 16'h0, 3'd0, 0);
      begin
        repeat (20) @(negedge clk);
        req_addr = 5'h01; req_wr = 1'b1; req = 1'b1;
        repeat (3) @(negedge clk);
        req = 1'b0;
      end
    join
    repeat (8) @(negedge clk);
    chk(!busy, "R10 no access after ignored request", busy, 0);
    chk(exp_q.size() == 0, "R10 scoreboard empty", exp_q.size(), 0);
    chk(dev_mem[1] == exp_mem[1], "R10 device register untouched", dev_mem[1], exp_mem[1]);

    // R1 reset in the middle of a strobe
    mon_off = 1;
    cur_dly = 0;
    @(negedge clk);
    req = 1'b1; req_wr = 1'b0; req_addr = 5'h15; req_mode = 3'd4;
    @(negedge clk);
    req = 1'b0;
    repeat (9) @(negedge clk);
    chk(!bus_rd_n, "R1 strobe low before mid reset", bus_rd_n, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(bus_rd_n && bus_wr_n && !busy, "R1 strobes after mid reset", {bus_rd_n, bus_wr_n, busy}, 6);
    chk(!bus_doe && bus_cs0_n && bus_cs1_n, "R1 doe/cs after mid reset", {bus_doe, bus_cs1_n, bus_cs0_n}, 3);
    rst_n = 1'b1;
    mon_off = 0;
    @(negedge clk);
    do_access(0, 5'h0A, 16'h0, 3'd1, 0);
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule